// File: doc/BRIEF.md
# Noise-Shaping Word Requantizer

This block shortens signed 16-bit audio words to signed 13-bit words, one word per sample strobe (nominally a 512 kHz rate derived from a faster system clock). Instead of discarding the three low bits outright, it keeps them in a one-sample delay register and adds them to the next incoming word before the next split. The truncation error is therefore high-pass shaped: its running sum stays bounded, so the low-frequency error energy drops, at the cost of more error near half the sample rate.

The block sits between an upstream sample source and a downstream narrow-word modulator. Each strobe yields one output word, marked by a single-cycle valid pulse on the following clock. Clipping is applied to the internal sum so that a full-scale positive input, together with a carried remainder, cannot wrap to a negative code.

Top module: `nsw_requant`

## Requirements
- R1: On a clock edge with `smp_en` high, `dout` takes the upper 13 bits of S, where S is `din` (signed) plus the held remainder, clipped to the range -32768..32767; `dout` is therefore floor(S/8), signed two's complement.
- R2: On that same edge the held remainder becomes the low 3 bits of S (S mod 8), and it is added to the next strobed input.
- R3: The remainder is added as an unsigned value 0..7 (zero-extended): an input of -8 always yields `dout` = -1, whatever the remainder.
- R4: S is clipped, never wrapped: an input of 32767 always yields `dout` = 4095, and the remainder then becomes 7.
- R5: `dout_vld` is high for exactly the one clock that follows each clock edge with `smp_en` high, and low otherwise.
- R6: A clock edge with `rst` high clears the remainder to 0, `dout` to 0 and `dout_vld` to 0; reset takes priority over `smp_en`.
- R7: A strobed input of 0 always yields `dout` = 0, so an all-zero input stream after reset gives an all-zero output.
- R8: Between strobes, `dout` and the remainder hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe, one clock wide per sample period |
| din | input | 16 | Signed input word |
| dout | output | 13 | Signed requantized word |
| dout_vld | output | 1 | Pulses high one clock after each strobe |

## Verification
The bench pushes a positive full-scale input on top of a carried remainder; a design that adds without clipping wraps to -4096 instead of holding 4095. It drives -8 with remainders from 0 to 7; sign-extending the remainder turns a remainder of 4..7 into a negative correction and gives -2. Long gaps between strobes expose a design that updates on every clock rather than on the strobe, and a mid-stream reset followed by a small input exposes a remainder that survives reset, since the stale carry lifts the output to 1.

// File: rtl/nsw_requant.sv
module nsw_requant #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int FRAC_W = IN_W - OUT_W;
  localparam int SUM_W  = IN_W + 1;

  logic [FRAC_W-1:0] rem_q;
  logic [SUM_W-1:0]  sum_w;
  logic              ovf_w;
  logic [IN_W-1:0]   sat_w;

  assign sum_w = {din[IN_W-1], din} + {{(SUM_W-FRAC_W){1'b0}}, rem_q};
  assign ovf_w = sum_w[SUM_W-1] ^ sum_w[SUM_W-2];
  assign sat_w = ovf_w ? {sum_w[SUM_W-1], {(IN_W-1){~sum_w[SUM_W-1]}}}
                       : sum_w[IN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= smp_en;
      if (smp_en) begin
        dout  <= sat_w[IN_W-1:FRAC_W];
        rem_q <= sat_w[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/nsw_requant_chk.sv
module nsw_requant_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_en,
  input logic signed [IN_W-1:0]  din,
  input logic signed [OUT_W-1:0] dout,
  input logic                    dout_vld
);
  localparam int FRAC_W = IN_W - OUT_W;
  localparam logic [IN_W-1:0]  IN_MAX  = {1'b0, {(IN_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [IN_W-1:0]  IN_NEG1 = {{OUT_W{1'b1}}, {FRAC_W{1'b0}}};

  logic rst_seen = 1'b0;
  always_ff @(posedge clk) rst_seen <= rst;

  // R6
  always_ff @(posedge clk)
    if (rst_seen) reset_clear_chk: assert (!dout_vld && dout == '0);

  // R5
  vld_follows_chk: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> dout_vld);

  // R5
  vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> !dout_vld);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(dout));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && din == IN_MAX) |=> dout == OUT_MAX);

  // R3
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && din == IN_NEG1) |=> dout == '1);

  // R7
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_en && din == '0) |=> dout == '0);
endmodule

bind nsw_requant nsw_requant_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .smp_en(smp_en), .din(din),
  .dout(dout), .dout_vld(dout_vld)
);

// File: tb/nsw_requant_bench.sv
module nsw_requant_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic signed [15:0] din = '0;
  logic signed [12:0] dout;
  logic dout_vld;

  int n_chk = 0;
  int n_bad = 0;
  int m_rem = 0;
  int m_out = 0;
  bit m_vld = 1'b0;
  string tag = "R6";

  always #4 clk = ~clk;

  nsw_requant u_nsw_requant (
    .clk(clk), .rst(rst), .smp_en(smp_en), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  task automatic compare();
    n_chk++;
    if (int'(dout) != m_out) begin
      n_bad++;
      $display("FAIL %s dout actual=%0d expected=%0d", tag, dout, m_out);
    end
    n_chk++;
    if (dout_vld !== m_vld) begin
      n_bad++;
      $display("FAIL R5 dout_vld actual=%0b expected=%0b", dout_vld, m_vld);
    end
  endtask

  // one clock: check current outputs, apply inputs, advance the model
  task automatic tick(input bit r, input bit en, input int d, input string t);
    @(negedge clk);
    compare();
    tag = t;
    rst = r; smp_en = en; din = 16'(d);
    if (r) begin
      m_rem = 0; m_out = 0; m_vld = 1'b0;
    end else if (en) begin
      int s;
      s = d + m_rem;
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      m_out = s >>> 3;
      m_rem = s & 7;
      m_vld = 1'b1;
    end else begin
      m_vld = 1'b0;
    end
  endtask

  task automatic sample(input int d, input string t, input int gap);
    tick(1'b0, 1'b1, d, t);
    for (int g = 0; g < gap; g++) tick(1'b0, 1'b0, 0, "R8");
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick(1'b1, 1'b0, 0, "R6");
    tick(1'b0, 1'b0, 0, "R6");
    // R7: zero stream
    for (int i = 0; i < 8; i++) sample(0, "R7", 3);
    // R1 R2: remainder carry with small constant
    for (int i = 0; i < 16; i++) sample(7, "R2", 3);
    for (int i = 0; i < 12; i++) sample(-3, "R1", 3);
    // R3: -8 under every remainder value
    for (int k = 0; k < 8; k++) begin
      sample(k, "R3", 1);
      sample(-8, "R3", 1);
    end
    // R4: positive full scale with carried remainder
    sample(5, "R4", 1);
    for (int i = 0; i < 4; i++) sample(32767, "R4", 1);
    sample(32760, "R4", 1);
    sample(-32768, "R1", 1);
    sample(-32768, "R1", 1);
    // R8: long gaps
    sample(1234, "R8", 20);
    sample(-999, "R8", 20);
    // R6: reset mid-stream with nonzero remainder, then small input
    sample(7, "R6", 1);
    tick(1'b1, 1'b1, 500, "R6");
    tick(1'b0, 1'b0, 0, "R6");
    sample(7, "R6", 3);
    // R5: back-to-back strobes, then mixed patterns
    for (int i = 0; i < 10; i++) sample(i * 301 - 1500, "R5", 0);
    for (int i = 0; i < 300; i++) sample(int'($urandom_range(65535)) - 32768, "R1", i % 4);
    tick(1'b0, 1'b0, 0, "R8");
    tick(1'b0, 1'b0, 0, "R8");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule